// File: doc/BRIEF.md
# Store Queue with Read Forwarding

This block sits between a cache and main memory and holds stores that have left the cache but not yet reached DRAM. The processor side pushes address/data pairs into a small in-order queue, and the memory controller pops them from the head and writes them out in the order they arrived. A queued store may be the only up-to-date copy of its word. For that reason, every read that is about to go to memory is first compared against every queued address in the same cycle.

In forwarding mode, a read whose address matches a queued store is answered straight from the queue. If several queued stores share that address, the data of the most recent one is returned. A read with no match gets a go-ahead to memory. In conservative mode, the block never forwards: a read gets its go-ahead only once the queue is completely empty.

A store offered in the same cycle as a read counts as already queued for that read. This has two uses. A dirty victim line can be pushed in the same cycle that the read miss for its replacement is sent to memory. A read of an address being stored in that cycle sees the new data.

Top module: `wbuf_fwd`

## Requirements
- R1: After reset the queue is empty: `drnValid` is 0 and `stReady` is 1.
- R2: Entries leave through the drain port in exactly the order they were accepted, with the address and data they were accepted with. The head entry holds steady while `drnReady` is low.
- R3: With DEPTH entries queued, `stReady` is 0. A store offered then is dropped and never appears on the drain port.
- R4: `drnValid` is 0 whenever no entry is queued.
- R5: In forwarding mode (`safeMode`=0), a valid read whose address equals a queued address gives `rdHit`=1 with that entry's data on `rdData`, and `rdGo`=0, in the same cycle.
- R6: In forwarding mode, a valid read that matches no queued address and no store accepted in that cycle gives `rdGo`=1 and `rdHit`=0.
- R7: When more than one queued entry matches, `rdData` is the data of the most recently accepted of them.
- R8: A store accepted in the same cycle as a read is visible to that read. If its address matches, it is the newest match, and its data is forwarded.
- R9: In conservative mode (`safeMode`=1), `rdHit` is never 1. `rdGo` is 1 only when the queue is empty and no store is accepted in that cycle.
- R10: In forwarding mode, a store to a different address accepted in the same cycle as a missing read is queued, and the read still gets `rdGo`=1. This is how a victim line is queued while its replacement is fetched.
- R11: `rdHit` and `rdGo` are never both 1. Both are 0 when `rdValid` is 0, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| safeMode | input | 1 | 1 = conservative mode (wait for empty queue), 0 = forwarding mode |
| stValid | input | 1 | Store offered |
| stAddr | input | ADDR_W | Store word address |
| stData | input | DATA_W | Store data |
| stReady | output | 1 | Queue can accept a store this cycle |
| rdValid | input | 1 | Read search request |
| rdAddr | input | ADDR_W | Read word address |
| rdHit | output | 1 | Read answered from the queue |
| rdData | output | DATA_W | Forwarded data, meaningful when `rdHit` is 1 |
| rdGo | output | 1 | Read may proceed to memory |
| drnValid | output | 1 | Head entry available to the memory controller |
| drnAddr | output | ADDR_W | Head entry address |
| drnData | output | DATA_W | Head entry data |
| drnReady | input | 1 | Memory controller takes the head entry |

## Verification
The read search and the store push can land in the same cycle, and the answer must include the store being accepted. The bench provokes this in two ways. It pushes a store together with a read of the same address, into both an empty and an already-matching queue. It also pushes a store to another address together with a missing read, which is the victim case. It judges the outcome by `rdHit`, `rdData` and `rdGo` in that cycle, and by the later drain order. A long random phase over a four-address space also mixes drains, full-queue stalls and mode changes into those coincident cycles. Expected answers in that phase come from a queue model kept in the bench.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
  } wbufStrobe_t;
endpackage

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             safeMode,
  input  logic             stValid,
  input  logic             drnReady,
  input  logic             rdValid,
  input  logic             fwdHit,
  output logic             stReady,
  output logic             drnValid,
  output logic             rdHit,
  output logic             rdGo,
  output wbufStrobe_t      strobe,
  output logic [CNT_W-1:0] count
);
  logic isFull, isEmpty;

  always_comb begin
    isFull       = (count == CNT_W'(DEPTH));
    isEmpty      = (count == '0);
    stReady      = !isFull;
    drnValid     = !isEmpty;
    strobe.push  = stValid && !isFull;
    strobe.pop   = !isEmpty && drnReady;
    rdHit        = rdValid && !safeMode && fwdHit;
    if (safeMode) rdGo = rdValid && isEmpty && !strobe.push;
    else          rdGo = rdValid && !fwdHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else       count <= count + CNT_W'(strobe.push) - CNT_W'(strobe.pop);
  end
endmodule

// File: rtl/wbuf_data.sv
module wbuf_data
  import wbuf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  wbufStrobe_t       strobe,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              fwdHit,
  output logic [DATA_W-1:0] fwdData,
  output logic [ADDR_W-1:0] drnAddr,
  output logic [DATA_W-1:0] drnData
);
  logic [ADDR_W-1:0] slotAddr [DEPTH];
  logic [DATA_W-1:0] slotData [DEPTH];
  logic [DEPTH-1:0]  slotMatch;
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] ringAdd(input logic [PTR_W-1:0] base, input int offs);
    int s;
    s = int'(base) + offs;
    if (s >= DEPTH) s = s - DEPTH;
    return PTR_W'(s);
  endfunction

  // one address comparator per slot
  for (genvar i = 0; i < DEPTH; i++) begin : gCmp
    assign slotMatch[i] = (slotAddr[i] == rdAddr);
  end

  // walk from oldest to newest so the newest match wins
  always_comb begin
    logic [PTR_W-1:0] idx;
    fwdHit  = 1'b0;
    fwdData = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = ringAdd(rdPtr, k);
      if (CNT_W'(k) < count && slotMatch[idx]) begin
        fwdHit  = 1'b1;
        fwdData = slotData[idx];
      end
    end
    if (strobe.push && stAddr == rdAddr) begin
      fwdHit  = 1'b1;
      fwdData = stData;
    end
  end

  assign drnAddr = slotAddr[rdPtr];
  assign drnData = slotData[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        slotAddr[i] <= '0;
        slotData[i] <= '0;
      end
    end else begin
      if (strobe.push) begin
        slotAddr[wrPtr] <= stAddr;
        slotData[wrPtr] <= stData;
        wrPtr           <= ringAdd(wrPtr, 1);
      end
      if (strobe.pop) rdPtr <= ringAdd(rdPtr, 1);
    end
  end
endmodule

// File: rtl/wbuf_fwd.sv
module wbuf_fwd
  import wbuf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              safeMode,
  input  logic              stValid,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  output logic              stReady,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              rdHit,
  output logic [DATA_W-1:0] rdData,
  output logic              rdGo,
  output logic              drnValid,
  output logic [ADDR_W-1:0] drnAddr,
  output logic [DATA_W-1:0] drnData,
  input  logic              drnReady
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  wbufStrobe_t      strobe;
  logic [CNT_W-1:0] count;
  logic             fwdHit;

  wbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .safeMode(safeMode), .stValid(stValid),
    .drnReady(drnReady), .rdValid(rdValid), .fwdHit(fwdHit),
    .stReady(stReady), .drnValid(drnValid), .rdHit(rdHit), .rdGo(rdGo),
    .strobe(strobe), .count(count)
  );

  wbuf_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .count(count),
    .stAddr(stAddr), .stData(stData), .rdAddr(rdAddr),
    .fwdHit(fwdHit), .fwdData(rdData), .drnAddr(drnAddr), .drnData(drnData)
  );
endmodule

// File: rtl/wbuf_fwd_chk.sv
module wbuf_fwd_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              safeMode,
  input logic              stValid,
  input logic [ADDR_W-1:0] stAddr,
  input logic [DATA_W-1:0] stData,
  input logic              stReady,
  input logic              rdValid,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdHit,
  input logic [DATA_W-1:0] rdData,
  input logic              rdGo,
  input logic              drnValid,
  input logic [ADDR_W-1:0] drnAddr,
  input logic [DATA_W-1:0] drnData,
  input logic              drnReady
);
  localparam int SH_W = $clog2(DEPTH + 1) + 1;
  logic [SH_W-1:0] shadow;
  logic            pushSeen, popSeen;

  assign pushSeen = stValid && stReady;
  assign popSeen  = drnValid && drnReady;

  always_ff @(posedge clk) begin
    if (!rstN) shadow <= '0;
    else       shadow <= shadow + SH_W'(pushSeen) - SH_W'(popSeen);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    shadow <= SH_W'(DEPTH)); // R3
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (shadow == SH_W'(DEPTH)) |-> !stReady); // R3
  AST_EMPTY_NO_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    (shadow == '0) |-> !drnValid); // R4
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (drnValid && !drnReady) |=> (drnValid && $stable(drnAddr) && $stable(drnData))); // R2
  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rstN)
    !(rdHit && rdGo)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (!rdHit && !rdGo)); // R11
  AST_SAFE_NO_FWD: assert property (@(posedge clk) disable iff (!rstN)
    safeMode |-> !rdHit); // R9
  AST_SAFE_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (safeMode && rdGo) |-> (shadow == '0 && !pushSeen)); // R9
  AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !safeMode && pushSeen && stAddr == rdAddr) |-> (rdHit && rdData == stData)); // R8
endmodule

bind wbuf_fwd wbuf_fwd_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .safeMode(safeMode), .stValid(stValid), .stAddr(stAddr),
  .stData(stData), .stReady(stReady), .rdValid(rdValid), .rdAddr(rdAddr),
  .rdHit(rdHit), .rdData(rdData), .rdGo(rdGo), .drnValid(drnValid),
  .drnAddr(drnAddr), .drnData(drnData), .drnReady(drnReady)
);

// File: tb/sim_wbuf_fwd.sv
`timescale 1ns/1ps
module sim_wbuf_fwd;
  localparam int AW = 8, DW = 16, DEPTH = 4;

  logic clk = 1'b0, rstN = 1'b0, safeMode = 1'b0;
  logic stValid = 1'b0, rdValid = 1'b0, drnReady = 1'b0;
  logic [AW-1:0] stAddr = '0, rdAddr = '0;
  logic [DW-1:0] stData = '0;
  logic stReady, rdHit, rdGo, drnValid;
  logic [DW-1:0] rdData, drnData;
  logic [AW-1:0] drnAddr;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  logic [AW-1:0] qa[$];
  logic [DW-1:0] qd[$];

  always #2.5 clk = ~clk;

  wbuf_fwd #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .safeMode(safeMode), .stValid(stValid), .stAddr(stAddr),
    .stData(stData), .stReady(stReady), .rdValid(rdValid), .rdAddr(rdAddr),
    .rdHit(rdHit), .rdData(rdData), .rdGo(rdGo), .drnValid(drnValid),
    .drnAddr(drnAddr), .drnData(drnData), .drnReady(drnReady)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, check before the posedge, advance the model
  task automatic step(input logic sV, input logic [AW-1:0] sA, input logic [DW-1:0] sD,
                      input logic rV, input logic [AW-1:0] rA, input logic dR, input string tag);
    logic expHit, expGo, stFire;
    logic [DW-1:0] expData;
    @(negedge clk);
    stValid = sV; stAddr = sA; stData = sD;
    rdValid = rV; rdAddr = rA; drnReady = dR;
    #1;
    stFire = sV && (qa.size() < DEPTH);
    expHit = 1'b0; expData = '0;
    if (rV && !safeMode) begin
      for (int k = 0; k < qa.size(); k++)
        if (qa[k] == rA) begin expHit = 1'b1; expData = qd[k]; end
      if (stFire && sA == rA) begin expHit = 1'b1; expData = sD; end
    end
    if (!rV) expGo = 1'b0;
    else if (safeMode) expGo = (qa.size() == 0) && !stFire;
    else expGo = !expHit;
    chk({tag, " rdHit"}, 32'(rdHit), 32'(expHit));
    chk({tag, " rdGo"}, 32'(rdGo), 32'(expGo));
    if (expHit) chk({tag, " rdData"}, 32'(rdData), 32'(expData));
    chk("R3 stReady", 32'(stReady), 32'(qa.size() < DEPTH));
    chk("R4 drnValid", 32'(drnValid), 32'(qa.size() != 0));
    if (qa.size() != 0) begin
      chk("R2 drnAddr", 32'(drnAddr), 32'(qa[0]));
      chk("R2 drnData", 32'(drnData), 32'(qd[0]));
    end
    if (dR && qa.size() != 0) begin void'(qa.pop_front()); void'(qd.pop_front()); end
    if (stFire) begin qa.push_back(sA); qd.push_back(sD); end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 drnValid", 32'(drnValid), 32'd0);
    chk("R1 stReady", 32'(stReady), 32'd1);

    // fill, then an extra store while full (R3)
    for (int i = 0; i < DEPTH; i++) step(1, AW'(8'h40 + i * 3), DW'(16'hA000 + i), 0, '0, 0, "R3");
    step(1, 8'h99, 16'hDEAD, 0, '0, 0, "R3");
    // sweep every read address against a full queue (R5 R6)
    for (int a = 0; a < (1 << AW); a++) step(0, '0, '0, 1, AW'(a), 0, "R5/R6");
    // idle read with matching address (R11)
    step(0, '0, '0, 0, 8'h40, 0, "R11");
    // drain, checking order and that the dropped store never shows (R2)
    for (int i = 0; i < DEPTH + 1; i++) step(0, '0, '0, 1, 8'h99, 1, "R2");

    // several entries with one address: newest wins (R7)
    step(1, 8'h10, 16'h1111, 0, '0, 0, "R7");
    step(1, 8'h10, 16'h2222, 0, '0, 0, "R7");
    step(1, 8'h20, 16'h3333, 0, '0, 0, "R7");
    step(1, 8'h10, 16'h4444, 1, 8'h10, 0, "R7");
    for (int i = 0; i < DEPTH + 1; i++) step(0, '0, '0, 1, 8'h10, 1, "R7");

    // same-cycle store and read (R8)
    step(1, 8'h33, 16'h5555, 1, 8'h33, 0, "R8");
    step(1, 8'h33, 16'h6666, 1, 8'h33, 0, "R8");
    // victim store beside a missing read (R10)
    step(1, 8'h44, 16'h7777, 1, 8'h55, 0, "R10");
    step(0, '0, '0, 1, 8'h44, 0, "R10");
    for (int i = 0; i < DEPTH; i++) step(0, '0, '0, 0, '0, 1, "R2");

    // conservative mode (R9)
    safeMode = 1'b1;
    step(1, 8'h60, 16'h8888, 1, 8'h60, 0, "R9");
    step(0, '0, '0, 1, 8'h60, 0, "R9");
    step(0, '0, '0, 1, 8'h61, 1, "R9");
    step(0, '0, '0, 1, 8'h61, 0, "R9");
    step(1, 8'h62, 16'h9999, 1, 8'h61, 1, "R9");
    step(0, '0, '0, 1, 8'h62, 1, "R9");
    step(0, '0, '0, 1, 8'h62, 0, "R9");
    safeMode = 1'b0;

    // random mixing, small address space
    for (int n = 0; n < 4000; n++) begin
      if (n == 2000) safeMode = 1'b1;
      if (n == 3000) safeMode = 1'b0;
      step($urandom_range(0, 1), AW'($urandom_range(0, 3)), DW'($urandom),
           $urandom_range(0, 3) != 0, AW'($urandom_range(0, 3)),
           $urandom_range(0, 2) == 0, "R7/R8");
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule